// File: doc/BRIEF.md
# Interval Timer Peripheral with Interrupt Registers

This block is a small register-mapped peripheral. A host writes and reads it through a 4-bit register address, an 8-bit write bus and an 8-bit read bus, each access qualified by a one-cycle strobe. It has two general output registers, each with a direction mask. It also has a 16-bit reloadable down-counter (timer one) backed by a 16-bit latch, and a second 16-bit down-counter (timer two) that wraps freely. Both counters advance only on cycles where the count-enable input is high.

Timer one runs in one of two modes, chosen by bit 6 of a mode register. In repeating mode it reloads from its latch on every expiry. In single mode it expires once per arming and then keeps wrapping without raising anything. Expiry sets bit 6 of a 7-bit event-flag register. A 7-bit mask register chooses which flags drive the active-high interrupt output. The flag register is cleared by writing ones. The mask register is set or cleared depending on bit 7 of the written byte.

Top module: `ivt_adapter`

## Requirements
- R1: After reset every register reads 0x00, except address 0xE, which reads 0x80. The irq output is low.
- R2: Address 0 reads output register B AND direction B. Address 1 reads output register A AND direction A. Addresses 2 and 3 read direction B and direction A.
- R3: A write to address 4 or 6 replaces only the low latch byte (read back at address 6). The timer-one counter (addresses 4/5 low/high) is not changed by it.
- R4: A write to address 5 sets the high latch byte and copies the whole latch into the timer-one counter. It also clears flag bit 6 and arms single mode.
- R5: A write to address 7 sets the high latch byte and clears flag bit 6. It leaves the counter unchanged.
- R6: Both counters decrement by one on each cycle with cnt_en high and hold otherwise. Timer two (read at addresses 8/9 low/high) wraps from 0x0000 to 0xFFFF.
- R7: With bit 6 of the mode register (address 0xB, read back in full) at 1, a count cycle that finds timer one at zero reloads it from the latch and sets flag bit 6.
- R8: With that mode bit at 0, a count at zero wraps timer one to 0xFFFF. Flag bit 6 is set only on the first such expiry after a write to address 5.
- R9: Reading address 0xD returns flag bits 6:0 in bits 6:0, and bit 7 is 1 exactly when any of them is 1.
- R10: Writing address 0xD clears each flag bit written as 1 and keeps the others.
- R11: Writing address 0xE with bit 7 = 1 sets the mask bits given as 1. With bit 7 = 0 it clears them. Bit 7 reads as 1.
- R12: irq is high exactly when some flag bit and its mask bit are both 1. It changes in the cycle after the causing edge. A flag set by expiry wins over a clear written in the same cycle.
- R13: reg_rdata takes the addressed value at the clock edge where reg_rd is high and holds otherwise. Reads have no side effects. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt request |

## Verification
Timer-one expiry can land in the same cycle as a host write that clears flag bit 6, either a flag-register write or a latch-high write to address 7. The bench steps its own model until timer one reaches zero. It then issues that write with cnt_en high in that very cycle. Reading back 0xC0 from the flag register, and a still-high irq, show that the set won. The model compares irq and read data on every clock.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [3:0] A_OUTB  = 4'h0;
  localparam logic [3:0] A_OUTA  = 4'h1;
  localparam logic [3:0] A_DIRB  = 4'h2;
  localparam logic [3:0] A_DIRA  = 4'h3;
  localparam logic [3:0] A_T1LO  = 4'h4;
  localparam logic [3:0] A_T1HI  = 4'h5;
  localparam logic [3:0] A_LATLO = 4'h6;
  localparam logic [3:0] A_LATHI = 4'h7;
  localparam logic [3:0] A_T2LO  = 4'h8;
  localparam logic [3:0] A_T2HI  = 4'h9;
  localparam logic [3:0] A_MODE  = 4'hB;
  localparam logic [3:0] A_FLAG  = 4'hD;
  localparam logic [3:0] A_MASK  = 4'hE;
endpackage

// File: rtl/ivt_timer1.sv
module ivt_timer1 #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_load,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  input  logic            continuous,
  output logic [2*DW-1:0] cnt,
  output logic [2*DW-1:0] latch,
  output logic            fire
);
  localparam int TW = 2 * DW;

  logic [TW-1:0] cnt_n, latch_n;
  logic          armed, armed_n, at_zero, expire;

  assign at_zero = (cnt == '0);
  assign expire  = tick && at_zero && !wr_load;
  assign fire    = expire && (continuous || armed);

  always_comb begin
    latch_n = latch;
    if (wr_lo)            latch_n[DW-1:0]  = wdata;
    if (wr_load || wr_hi) latch_n[TW-1:DW] = wdata;
  end

  always_comb begin
    cnt_n = cnt;
    if (wr_load)                  cnt_n = {wdata, latch[DW-1:0]};
    else if (tick && at_zero && continuous) cnt_n = latch;
    else if (tick)                cnt_n = cnt - 1'b1;
  end

  always_comb begin
    armed_n = armed;
    if (wr_load)                  armed_n = 1'b1;
    else if (expire && !continuous) armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
      armed <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      latch <= latch_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/ivt_timer2.sv
module ivt_timer2 #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [2*DW-1:0] cnt
);
  logic [2*DW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (tick) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/ivt_irq_regs.sv
module ivt_irq_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t1_set,
  input  logic          t1_clr,
  input  logic          flag_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-2:0] flags,
  output logic [DW-2:0] mask,
  output logic          irq
);
  localparam int NF = DW - 1;
  localparam int T1B = NF - 1;

  logic [NF-1:0] flags_n, mask_n;

  always_comb begin
    flags_n = flags;
    if (flag_wr) flags_n = flags_n & ~wdata[NF-1:0];
    if (t1_clr)  flags_n[T1B] = 1'b0;
    if (t1_set)  flags_n[T1B] = 1'b1;
  end

  always_comb begin
    mask_n = mask;
    if (mask_wr) begin
      if (wdata[DW-1]) mask_n = mask | wdata[NF-1:0];
      else             mask_n = mask & ~wdata[NF-1:0];
    end
  end

  assign irq = |(flags & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flags_n;
      mask  <= mask_n;
    end
  end
endmodule

// File: rtl/ivt_adapter.sv
module ivt_adapter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  import ivt_pkg::*;
  localparam int TW = 2 * DW;
  localparam int NF = DW - 1;

  logic [DW-1:0] out_a, out_b, dir_a, dir_b, mode;
  logic [DW-1:0] out_a_n, out_b_n, dir_a_n, dir_b_n, mode_n, rdata_n;
  logic [TW-1:0] t1_cnt, t1_latch, t2_cnt;
  logic [NF-1:0] flags, mask;
  logic          t1_fire, continuous;

  function automatic logic hit(input logic [3:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  assign continuous = mode[6];

  ivt_timer1 #(.DW(DW)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en),
    .wr_lo(hit(A_T1LO) || hit(A_LATLO)),
    .wr_load(hit(A_T1HI)),
    .wr_hi(hit(A_LATHI)),
    .wdata(reg_wdata), .continuous(continuous),
    .cnt(t1_cnt), .latch(t1_latch), .fire(t1_fire)
  );

  ivt_timer2 #(.DW(DW)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .cnt(t2_cnt)
  );

  ivt_irq_regs #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .t1_set(t1_fire),
    .t1_clr(hit(A_T1HI) || hit(A_LATHI)),
    .flag_wr(hit(A_FLAG)), .mask_wr(hit(A_MASK)),
    .wdata(reg_wdata), .flags(flags), .mask(mask), .irq(irq)
  );

  always_comb begin
    out_a_n = hit(A_OUTA) ? reg_wdata : out_a;
    out_b_n = hit(A_OUTB) ? reg_wdata : out_b;
    dir_a_n = hit(A_DIRA) ? reg_wdata : dir_a;
    dir_b_n = hit(A_DIRB) ? reg_wdata : dir_b;
    mode_n  = hit(A_MODE) ? reg_wdata : mode;
  end

  always_comb begin
    unique case (reg_addr)
      A_OUTB:  rdata_n = out_b & dir_b;
      A_OUTA:  rdata_n = out_a & dir_a;
      A_DIRB:  rdata_n = dir_b;
      A_DIRA:  rdata_n = dir_a;
      A_T1LO:  rdata_n = t1_cnt[DW-1:0];
      A_T1HI:  rdata_n = t1_cnt[TW-1:DW];
      A_LATLO: rdata_n = t1_latch[DW-1:0];
      A_LATHI: rdata_n = t1_latch[TW-1:DW];
      A_T2LO:  rdata_n = t2_cnt[DW-1:0];
      A_T2HI:  rdata_n = t2_cnt[TW-1:DW];
      A_MODE:  rdata_n = mode;
      A_FLAG:  rdata_n = {|flags, flags};
      A_MASK:  rdata_n = {1'b1, mask};
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a     <= '0;
      out_b     <= '0;
      dir_a     <= '0;
      dir_b     <= '0;
      mode      <= '0;
      reg_rdata <= '0;
    end else begin
      out_a <= out_a_n;
      out_b <= out_b_n;
      dir_a <= dir_a_n;
      dir_b <= dir_b_n;
      mode  <= mode_n;
      if (reg_rd) reg_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/ivt_adapter_chk.sv
module ivt_adapter_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cnt_en,
  input logic [3:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            reg_wr,
  input logic            irq,
  input logic            continuous,
  input logic            t1_fire,
  input logic [2*DW-1:0] t1_cnt,
  input logic [2*DW-1:0] t1_latch,
  input logic [2*DW-1:0] t2_cnt,
  input logic [DW-2:0]   flags
);
  localparam int TW = 2 * DW;

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'h5 |=> t1_cnt == {$past(reg_wdata), $past(t1_latch[DW-1:0])});

  assert_lo_keeps_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == 4'h4 || reg_addr == 4'h6) && !cnt_en |=> $stable(t1_cnt));

  assert_hi_keeps_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'h7 && !cnt_en |=> $stable(t1_cnt));

  assert_t2_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> t2_cnt == TW'($past(t2_cnt) - 1'b1));

  assert_t2_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(t2_cnt));

  assert_fire_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t1_fire |=> flags[DW-2]);

  assert_single_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    t1_fire && !continuous |=> !t1_fire);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'hD && reg_wdata[DW-2] && !t1_fire |=> !flags[DW-2]);

  assert_mask_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'hE && !reg_wdata[DW-1] && (&reg_wdata[DW-2:0]) |=> !irq);
endmodule

bind ivt_adapter ivt_adapter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_wr(reg_wr), .irq(irq),
  .continuous(continuous), .t1_fire(t1_fire), .t1_cnt(t1_cnt),
  .t1_latch(t1_latch), .t2_cnt(t2_cnt), .flags(flags)
);

// File: tb/ivt_adapter_bench.sv
module ivt_adapter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_en = 1'b0, d_wr = 1'b0, d_rd = 1'b0;
  logic [3:0] d_addr = 4'h0;
  logic [7:0] d_wd = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         total = 0, bad = 0;
  bit         done = 0;

  // behavioural reference state
  logic [15:0] m_t1, m_lat, m_t2;
  logic [7:0]  m_a, m_b, m_da, m_db, m_mode, m_rd;
  logic [6:0]  m_fl, m_mk;
  bit          m_arm;

  always #2 clk = ~clk;

  ivt_adapter u_ivt_adapter (
    .clk(clk), .rst_n(rst_n), .cnt_en(d_en), .reg_addr(d_addr),
    .reg_wdata(d_wd), .reg_wr(d_wr), .reg_rd(d_rd),
    .reg_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_t1 = 0; m_lat = 0; m_t2 = 0; m_a = 0; m_b = 0; m_da = 0; m_db = 0;
    m_mode = 0; m_rd = 0; m_fl = 0; m_mk = 0; m_arm = 0;
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return m_b & m_db;
      4'h1: return m_a & m_da;
      4'h2: return m_db;
      4'h3: return m_da;
      4'h4: return m_t1[7:0];
      4'h5: return m_t1[15:8];
      4'h6: return m_lat[7:0];
      4'h7: return m_lat[15:8];
      4'h8: return m_t2[7:0];
      4'h9: return m_t2[15:8];
      4'hB: return m_mode;
      4'hD: return {(m_fl != 0), m_fl};
      4'hE: return {1'b1, m_mk};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    bit wr5, go, rep;
    logic [15:0] old_lat;
    wr5 = d_wr && d_addr == 4'h5;
    rep = m_mode[6];
    old_lat = m_lat;
    go = d_en && m_t1 == 0 && !wr5 && (rep || m_arm);
    if (d_rd) m_rd = model_read(d_addr);
    if (d_en) m_t2 = m_t2 - 16'd1;
    if (d_en && !wr5) begin
      if (m_t1 == 0 && rep) m_t1 = old_lat;
      else m_t1 = m_t1 - 16'd1;
      if (m_t1 == 16'hFFFF && !rep) m_arm = 0;
    end
    if (d_wr) begin
      case (d_addr)
        4'h0: m_b = d_wd;
        4'h1: m_a = d_wd;
        4'h2: m_db = d_wd;
        4'h3: m_da = d_wd;
        4'h4, 4'h6: m_lat[7:0] = d_wd;
        4'h5: begin m_lat[15:8] = d_wd; m_t1 = m_lat; m_arm = 1; m_fl[6] = 0; end
        4'h7: begin m_lat[15:8] = d_wd; m_fl[6] = 0; end
        4'hB: m_mode = d_wd;
        4'hD: m_fl = m_fl & ~d_wd[6:0];
        4'hE: m_mk = d_wd[7] ? (m_mk | d_wd[6:0]) : (m_mk & ~d_wd[6:0]);
        default: ;
      endcase
    end
    if (go) m_fl[6] = 1;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    chk("R12 irq", {15'd0, irq}, {15'd0, |(m_fl & m_mk)});
    chk("R13 rdata", {8'd0, rdata}, {8'd0, m_rd});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    d_wr = 1; d_addr = a; d_wd = v;
    cyc();
    d_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    d_rd = 1; d_addr = a;
    cyc();
    d_rd = 0;
    chk(tag, {8'd0, rdata}, {8'd0, exp});
  endtask

  task automatic run_to_zero();
    d_en = 1;
    while (m_t1 != 0) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd(4'hE, 8'h80, "R1 mask read");
    rd(4'hD, 8'h00, "R1 flag read");
    rd(4'h5, 8'h00, "R1 t1 high");
    rd(4'hC, 8'h00, "R13 unmapped");
    // R2 port and direction registers
    wr(4'h3, 8'h0F); wr(4'h1, 8'hAB);
    rd(4'h1, 8'h0B, "R2 port A masked");
    rd(4'h3, 8'h0F, "R2 dir A");
    wr(4'h2, 8'hF0); wr(4'h0, 8'h5A);
    rd(4'h0, 8'h50, "R2 port B masked");
    rd(4'h2, 8'hF0, "R2 dir B");
    // R4 load through address 5
    wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    rd(4'h4, 8'h34, "R4 counter low");
    rd(4'h5, 8'h12, "R4 counter high");
    // R3 low latch writes leave counter
    wr(4'h6, 8'h99);
    rd(4'h4, 8'h34, "R3 counter low kept");
    rd(4'h6, 8'h99, "R3 latch low");
    // R5 high latch write leaves counter
    wr(4'h7, 8'h56);
    rd(4'h5, 8'h12, "R5 counter high kept");
    rd(4'h7, 8'h56, "R5 latch high");
    // R6 timer two wraps from zero
    d_en = 1; cyc(); d_en = 0;
    rd(4'h8, 8'hFF, "R6 t2 low wrap");
    rd(4'h9, 8'hFF, "R6 t2 high wrap");
    rd(4'h4, 8'h33, "R6 t1 step");
    // R11 mask set/clear
    wr(4'hE, 8'hC1);
    rd(4'hE, 8'hC1, "R11 mask set");
    wr(4'hE, 8'h01);
    rd(4'hE, 8'hC0, "R11 mask clear");
    // R7 repeating mode with short period
    wr(4'hB, 8'h40);
    rd(4'hB, 8'h40, "R7 mode readback");
    wr(4'h6, 8'h03); wr(4'h7, 8'h00); wr(4'h5, 8'h00);
    run_to_zero(); cyc(); d_en = 0;
    rd(4'hD, 8'hC0, "R9 flag summary");
    chk("R7 irq high", {15'd0, irq}, 16'd1);
    rd(4'h4, 8'h03, "R7 reload");
    // R10 flag clear by ones
    wr(4'hD, 8'h3F);
    rd(4'hD, 8'hC0, "R10 zero bit kept");
    wr(4'hD, 8'h40);
    rd(4'hD, 8'h00, "R10 cleared");
    // R12 collision: flag write clear meets expiry
    run_to_zero();
    d_wr = 1; d_addr = 4'hD; d_wd = 8'h40; cyc(); d_wr = 0; d_en = 0;
    rd(4'hD, 8'hC0, "R12 set beats flag clear");
    chk("R12 irq after collision", {15'd0, irq}, 16'd1);
    // R12 collision: latch-high write meets expiry
    wr(4'hD, 8'h40);
    run_to_zero();
    d_wr = 1; d_addr = 4'h7; d_wd = 8'h00; cyc(); d_wr = 0; d_en = 0;
    rd(4'hD, 8'hC0, "R12 set beats latch clear");
    wr(4'hE, 8'h40);
    chk("R12 irq masked", {15'd0, irq}, 16'd0);
    wr(4'hE, 8'hC0);
    // R8 single mode
    wr(4'hD, 8'h7F);
    wr(4'hB, 8'h00);
    wr(4'h6, 8'h02); wr(4'h5, 8'h00);
    run_to_zero(); cyc(); d_en = 0;
    rd(4'hD, 8'hC0, "R8 first expiry");
    rd(4'h5, 8'hFF, "R8 wrap high");
    wr(4'hD, 8'h40);
    run_to_zero(); cyc(); cyc(); d_en = 0;
    rd(4'hD, 8'h00, "R8 no second flag");
    chk("R8 irq low", {15'd0, irq}, 16'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule